// File: doc/BRIEF.md
# Quadlet Checksum Engine (CRC-16, Nibble-Serial)

This block computes the 16-bit check value that protects configuration-ROM style headers. Software or a neighbouring sequencer pulses `startIn` with the number of 32-bit quadlets to cover. The engine then accepts those quadlets on a valid/ready stream and folds each one into a 16-bit running value, four bits per clock. It starts with the most significant nibble of each quadlet.

When the last quadlet has been folded in, the engine pulses `doneOut` for one cycle. It presents the final check value on `crcOut`. It also presents a ready-made header word on `headerOut`, which places the covered length above the check value. Both outputs hold until the next accepted start. A count of zero finishes at once with a check value of zero.

Top module: `romCrcEngine`

## Requirements
- R1: After reset, `crcOut` is 0x0000, `headerOut` is 0x00000000, and `doneOut`, `inReady` and `busyOut` are low.
- R2: A start accepted while idle loads the count into `headerOut[31:16]` and clears `crcOut` to 0x0000 by the next cycle.
- R3: Each quadlet is consumed as eight nibbles, bits 31:28 first and bits 3:0 last. For each nibble, s = (crc[15:12] XOR nibble) & 0xF. The new crc is (crc << 4) XOR (s << 12) XOR (s << 5) XOR s, kept to 16 bits. A single quadlet 0x00000001 therefore yields 0x1021.
- R4: Exactly the started number of quadlets is consumed. `doneOut` rises in the cycle after the eighth nibble of the last quadlet, and `crcOut` then holds the final value.
- R5: Each quadlet costs eight cycles. After a handshake (`inValid` and `inReady` high at a clock edge), `inReady` stays low for the next seven cycles. With a continuous stream, handshakes are spaced exactly eight cycles apart.
- R6: A start pulse that arrives while `busyOut` is high is ignored. The length and check value of the running job are unaffected.
- R7: `doneOut` is high for exactly one cycle per job. While idle and without a start, `crcOut` and `headerOut` do not change.
- R8: A start with count 0 raises `doneOut` in the next cycle with `crcOut` = 0x0000. No quadlet is accepted, and `busyOut` stays low.
- R9: `headerOut` carries the covered length in bits 31:16 and the check value in bits 15:0.
- R10: While `inValid` is low, no data is consumed, whatever `inData` carries. Gaps in the stream only delay the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse; sampled only while idle |
| countIn | input | LEN_W (16) | Number of quadlets to cover |
| inValid | input | 1 | Quadlet on `inData` is valid |
| inData | input | DATA_W (32) | Quadlet data |
| inReady | output | 1 | Engine takes a quadlet this cycle if valid |
| busyOut | output | 1 | A job is in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| crcOut | output | 16 | Check value, final after `doneOut` |
| headerOut | output | LEN_W+16 (32) | {length, check value} |

## Verification
The bench goes after the zero-count job, which a design that always waits for a first quadlet would leave hanging with no done pulse. It checks nibble order with the lone quadlet 0x00000001: an engine that starts from the low nibble returns a different value from 0x1021. Stray start pulses are injected in the middle of a job; an engine that restarts on them loses the length or the partial check value. Gapped streams carrying junk data while `inValid` is low catch a datapath that samples data without a handshake. Back-to-back streams measure the handshake spacing, which an off-by-one nibble counter would stretch to nine cycles or cut to seven.

// File: rtl/romcrc_pkg.sv
package romcrc_pkg;

  localparam int CRC_W = 16;
  localparam int NIB_W = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearCrc;   // zero the running value
    logic loadLen;    // capture the quadlet count
    logic stepNib;    // fold one nibble
    logic selInput;   // nibble comes straight from the input bus
    logic loadWord;   // capture the remaining nibbles of the input word
  } ctrlStrobes_t;

  // One four-bit update of the running check value
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] crc,
                                               input logic [NIB_W-1:0] nib);
    logic [NIB_W-1:0] s;
    logic [CRC_W-1:0] res;
    s   = crc[CRC_W-1 -: NIB_W] ^ nib;
    res = {crc[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}};
    res = res ^ {s, 12'h000};
    res = res ^ {7'b0, s, 5'b0};
    res = res ^ {12'h000, s};
    return res;
  endfunction

endpackage

// File: rtl/romcrc_ctrl.sv
module romcrc_ctrl
  import romcrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [LEN_W-1:0] countIn,
  input  logic             inValid,
  output logic             inReady,
  output logic             busy,
  output logic             done,
  output ctrlStrobes_t     strobes
);

  localparam int NIBS  = DATA_W / NIB_W;
  localparam int IDX_W = $clog2(NIBS);
  localparam logic [IDX_W-1:0] LAST_NIB = IDX_W'(NIBS - 1);
  localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ACCEPT, S_SHIFT} state_t;

  state_t           state;
  logic [LEN_W-1:0] remaining;
  logic [IDX_W-1:0] nibIdx;
  logic             doneQ;

  assign busy    = (state != S_IDLE);
  assign inReady = (state == S_ACCEPT);
  assign done    = doneQ;

  always_comb begin
    strobes = '0;
    unique case (state)
      S_IDLE: begin
        if (startIn) begin
          strobes.clearCrc = 1'b1;
          strobes.loadLen  = 1'b1;
        end
      end
      S_ACCEPT: begin
        if (inValid) begin
          strobes.stepNib  = 1'b1;
          strobes.selInput = 1'b1;
          strobes.loadWord = 1'b1;
        end
      end
      S_SHIFT: strobes.stepNib = 1'b1;
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
      nibIdx    <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (startIn) begin
            if (countIn == '0) begin
              doneQ <= 1'b1;
            end else begin
              remaining <= countIn;
              state     <= S_ACCEPT;
            end
          end
        end
        S_ACCEPT: begin
          if (inValid) begin
            nibIdx <= IDX_W'(1);
            state  <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (nibIdx == LAST_NIB) begin
            if (remaining == ONE_LEFT) begin
              doneQ <= 1'b1;
              state <= S_IDLE;
            end else begin
              remaining <= remaining - ONE_LEFT;
              state     <= S_ACCEPT;
            end
          end else begin
            nibIdx <= nibIdx + IDX_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: after a handshake the engine is busy with that word next cycle
  assert_ready_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R5: ready only while a job is open
  assert_ready_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a start while busy does not abort the job
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && busy) |=> (busy || done));

endmodule

// File: rtl/romcrc_datapath.sv
module romcrc_datapath
  import romcrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [LEN_W-1:0]       countIn,
  input  logic [DATA_W-1:0]      inData,
  output logic [CRC_W-1:0]       crcOut,
  output logic [LEN_W+CRC_W-1:0] headerOut
);

  logic [CRC_W-1:0]  crcQ;
  logic [DATA_W-1:0] shiftQ;
  logic [LEN_W-1:0]  lenQ;
  logic [NIB_W-1:0]  curNib;

  assign curNib = strobes.selInput ? inData[DATA_W-1 -: NIB_W]
                                   : shiftQ[DATA_W-1 -: NIB_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ   <= '0;
      shiftQ <= '0;
      lenQ   <= '0;
    end else begin
      if (strobes.clearCrc)     crcQ <= '0;
      else if (strobes.stepNib) crcQ <= crcStep(crcQ, curNib);

      if (strobes.loadWord)     shiftQ <= {inData[DATA_W-NIB_W-1:0], {NIB_W{1'b0}}};
      else if (strobes.stepNib) shiftQ <= {shiftQ[DATA_W-NIB_W-1:0], {NIB_W{1'b0}}};

      if (strobes.loadLen)      lenQ <= countIn;
    end
  end

  assign crcOut    = crcQ;
  assign headerOut = {lenQ, crcQ};

  // R2: a clear strobe from control leaves the running value at zero
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCrc |=> (crcQ == '0));

endmodule

// File: rtl/romCrcEngine.sv
module romCrcEngine
  import romcrc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startIn,
  input  logic [LEN_W-1:0]       countIn,
  input  logic                   inValid,
  input  logic [DATA_W-1:0]      inData,
  output logic                   inReady,
  output logic                   busyOut,
  output logic                   doneOut,
  output logic [CRC_W-1:0]       crcOut,
  output logic [LEN_W+CRC_W-1:0] headerOut
);

  ctrlStrobes_t strobes;

  romcrc_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .countIn (countIn),
    .inValid (inValid),
    .inReady (inReady),
    .busy    (busyOut),
    .done    (doneOut),
    .strobes (strobes)
  );

  romcrc_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .countIn   (countIn),
    .inData    (inData),
    .crcOut    (crcOut),
    .headerOut (headerOut)
  );

  // R8: zero-length job finishes next cycle with a zero value
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut && countIn == '0) |=> (doneOut && crcOut == '0 && !busyOut));

  // R2: accepted start places the count in the header's upper half
  assert_len_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> (headerOut[LEN_W+CRC_W-1:CRC_W] == $past(countIn)));

  // R7: idle without a start keeps the result stable
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && !startIn) |=> ($stable(crcOut) && $stable(headerOut)));

endmodule

// File: tb/tb_romCrcEngine.sv
module tb_romCrcEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [15:0] countIn = '0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady, busyOut, doneOut;
  logic [15:0] crcOut;
  logic [31:0] headerOut;

  int total = 0;
  int bad   = 0;
  int cycle = 0;
  int hsCycle [0:15];
  logic [15:0] expCrcQ [$];
  logic [15:0] expLenQ [$];
  logic prevDone = 1'b0;

  romCrcEngine dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .countIn(countIn),
    .inValid(inValid), .inData(inData), .inReady(inReady), .busyOut(busyOut),
    .doneOut(doneOut), .crcOut(crcOut), .headerOut(headerOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [31:0] w [0:15], input int n);
    logic [15:0] c = 16'h0;
    for (int i = 0; i < n; i++) begin
      for (int sh = 28; sh >= 0; sh -= 4) begin
        logic [3:0] s;
        s = c[15:12] ^ w[i][sh +: 4];
        c = (c << 4) ^ ({12'h0, s} << 12) ^ ({12'h0, s} << 5) ^ {12'h0, s};
      end
    end
    return c;
  endfunction

  // Monitor: scoreboard compare on each done pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && doneOut) check(1'b0, "R7 done wider than one cycle", 32'd1, 32'd0);
      if (doneOut) begin
        if (expCrcQ.size() == 0) begin
          check(1'b0, "R4 unexpected done", 32'd1, 32'd0);
        end else begin
          logic [15:0] ec, el;
          ec = expCrcQ.pop_front();
          el = expLenQ.pop_front();
          check(crcOut == ec, "R4 R3 final crc", {16'h0, crcOut}, {16'h0, ec});
          check(headerOut == {el, ec}, "R9 header word", headerOut, {el, ec});
        end
      end
    end
    prevDone = doneOut;
  end

  // Watchdog
  initial begin
    wait (cycle > 150000);
    check(1'b0, "watchdog expired", cycle, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic pulseStart(input logic [15:0] n);
    @(negedge clk);
    startIn = 1'b1;
    countIn = n;
    @(negedge clk);
    startIn = 1'b0;
    countIn = 16'hBEEF;
  endtask

  // Driver: push expected result, start, stream words
  task automatic sendJob(input logic [31:0] w [0:15], input int n, input int gaps,
                         input logic poke);
    expCrcQ.push_back(model(w, n));
    expLenQ.push_back(16'(n));
    pulseStart(16'(n));
    if (n != 0) check(crcOut == 16'h0, "R2 cleared after start", {16'h0, crcOut}, 32'h0);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gaps; g++) begin
        inValid = 1'b0;
        inData  = 32'hDEAD_0000 | 32'(g);    // junk while not valid (R10)
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = w[i];
      while (!inReady) @(negedge clk);
      hsCycle[i] = cycle;
      @(negedge clk);
      inValid = 1'b0;
      inData  = 32'h5A5A_5A5A;
      if (poke && i == 0) begin
        startIn = 1'b1;                      // R6: stray start while busy
        countIn = 16'd9;
        @(negedge clk);
        startIn = 1'b0;
      end
    end
    while (expCrcQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] w [0:15];
    logic [31:0] lcg;
    logic [15:0] held;
    for (int i = 0; i < 16; i++) w[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(crcOut == 0, "R1 crc after reset", {16'h0, crcOut}, 0);
    check(headerOut == 0, "R1 header after reset", headerOut, 0);
    check(!doneOut && !inReady && !busyOut, "R1 flags after reset",
          {29'h0, doneOut, inReady, busyOut}, 0);

    // R3 nibble order: 0x00000001 -> 0x1021
    w[0] = 32'h0000_0001;
    sendJob(w, 1, 0, 1'b0);
    check(crcOut == 16'h1021, "R3 single low nibble", {16'h0, crcOut}, 32'h1021);

    // R7 stability while idle
    held = crcOut;
    repeat (10) @(negedge clk);
    check(crcOut == held && headerOut == {16'd1, held}, "R7 idle stable",
          {16'h0, crcOut}, {16'h0, held});

    // R8 zero-count job
    expCrcQ.push_back(16'h0);
    expLenQ.push_back(16'h0);
    @(negedge clk);
    startIn = 1'b1; countIn = 16'd0;
    @(negedge clk);
    startIn = 1'b0;
    check(doneOut == 1'b1, "R8 done next cycle", {31'h0, doneOut}, 1);
    check(crcOut == 0 && !busyOut && !inReady, "R8 zero result, not busy",
          {15'h0, busyOut, crcOut}, 0);
    @(negedge clk);

    // R5 back-to-back spacing, five words
    lcg = 32'h1234_5678;
    for (int i = 0; i < 5; i++) begin lcg = lcg * 32'd1664525 + 32'd1013904223; w[i] = lcg; end
    sendJob(w, 5, 0, 1'b0);
    for (int i = 1; i < 5; i++)
      check(hsCycle[i] - hsCycle[i-1] == 8, "R5 handshake spacing",
            32'(hsCycle[i] - hsCycle[i-1]), 8);

    // R10 gapped stream with junk data
    sendJob(w, 4, 3, 1'b0);

    // R6 stray start during job
    w[0] = 32'hFFFF_FFFF; w[1] = 32'h8000_0000; w[2] = 32'h0F0F_0F0F;
    sendJob(w, 3, 1, 1'b1);
    check(!busyOut, "R6 no second job launched", {31'h0, busyOut}, 0);

    // R4 R9 assorted lengths
    for (int n = 1; n <= 12; n += 3) begin
      for (int i = 0; i < n; i++) begin lcg = lcg * 32'd1664525 + 32'd1013904223; w[i] = lcg ^ 32'(n); end
      sendJob(w, n, n % 2, 1'b0);
    end
    check(expCrcQ.size() == 0, "R4 all jobs completed", 32'(expCrcQ.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule